// File: doc/BRIEF.md
# Video Pixel Clock Divider with Fixed Taps

This block is one stage of a video clock tree. A source selector chooses one of several tick streams, for example the output of a PLL post-divider. A programmable integer divider then thins that stream, and a bank of fixed taps derives five slower rates from the divided stream. Three consumers each pick one tap through their own selector and have their own output gate. The consumers are the HDMI transmitter pixel clock, the progressive encoder clock and the interlaced encoder clock.

The whole stage uses clock enables. Every rate is a train of one-cycle pulses in the input clock domain, so downstream logic stays on a single clock and qualifies its registers with these pulses. All configuration arrives on plain register-style inputs, which are held static by the surrounding control logic. A global enable and a soft reset act on the whole stage. The soft reset returns every counter to zero, so all taps restart in phase.

Top module: `vclk_tap_tree`

## Requirements
- R1: The divider ratio field is 8 bits wide and holds the ratio minus one. With a ratio field of N, the divided train carries one pulse for every N+1 selected source ticks.
- R2: The divider advances only while its enable input is 1 and its divider-reset input is 0. Otherwise all three consumer outputs stay low, and the divider and tap counters are held at zero.
- R3: Five taps are derived from the divided train. They divide it by 1, 2, 4, 6 and 12 respectively.
- R4: The tap gate vector has bit 0 for /1, bit 1 for /2, bit 2 for /4, bit 3 for /6 and bit 4 for /12. A consumer whose selected tap has its gate bit at 0 produces no pulses.
- R5: Each consumer has a 4-bit select, coded 0=/1, 1=/2, 2=/4, 3=/6 and 4=/12, and the same code is used for all three consumers. Codes 5 to 15 give a constant-low output.
- R6: A consumer whose own enable is 0 produces no pulses.
- R7: While the global enable is 0, all three outputs are low.
- R8: While soft reset is 1, all counters are held at zero. Once it is released with the divider running, every selected tap fires its first pulse on the same cycle, so the taps stay phase-aligned.
- R9: The 3-bit source select picks the tick input with the same index; index 0 is the primary PLL path.
- R10: The reset is synchronous and active high, and it drives all three outputs low.
- R11: Each consumer output is registered. A pulse appears one cycle after the clock edge at which the selected source tick completes a tap period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock domain for every pulse train |
| rst | input | 1 | Synchronous active-high reset |
| src_tick_i | input | 8 | Candidate source tick streams, one bit each |
| src_sel_i | input | 3 | Source select; 0 is the primary PLL path |
| glb_en_i | input | 1 | Global enable for the stage |
| soft_rst_i | input | 1 | Soft reset; clears and realigns all counters |
| div_ratio_m1_i | input | 8 | Divider ratio minus one |
| div_en_i | input | 1 | Divider enable |
| div_rst_i | input | 1 | Divider reset, active high |
| tap_gate_i | input | 5 | Per-tap gate enables, bit k for tap k |
| hdmi_sel_i | input | 4 | Tap select for the HDMI pixel output |
| hdmi_en_i | input | 1 | HDMI pixel output gate |
| encp_sel_i | input | 4 | Tap select for the progressive encoder output |
| encp_en_i | input | 1 | Progressive encoder output gate |
| enci_sel_i | input | 4 | Tap select for the interlaced encoder output |
| enci_en_i | input | 1 | Interlaced encoder output gate |
| hdmi_pix_o | output | 1 | HDMI pixel clock enable pulses |
| encp_clk_o | output | 1 | Progressive encoder clock enable pulses |
| enci_clk_o | output | 1 | Interlaced encoder clock enable pulses |

## Verification
The main function is exercised with three kinds of source stream: a tick on every cycle, a tick on every third cycle, and an idle stream. Each is combined with divider ratios of 1, 2, 3, 5 and 12. The stimulus table covers every tap code, so a pulse count over a window divisible by every expected period distinguishes a wrong divider ratio from a wrong tap ratio or a wrong source index. Further patterns switch off a tap gate, select illegal codes or close a consumer gate while the other consumers keep running, which separates the gating paths from one another. A final soft-reset release with the /2, /4 and /12 taps selected shows whether the taps start in phase.

// File: rtl/vclk_pkg.sv
package vclk_pkg;

    localparam int NUM_TAPS  = 5;
    localparam int NUM_CONS  = 3;
    localparam int SEL_W     = 4;

    typedef enum logic [SEL_W-1:0] {
        TAP_D1  = 4'd0,
        TAP_D2  = 4'd1,
        TAP_D4  = 4'd2,
        TAP_D6  = 4'd3,
        TAP_D12 = 4'd4
    } tap_sel_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             en;
    } cons_cfg_t;

    // Division ratio of tap number idx relative to the divided train.
    function automatic int tap_ratio(input int idx);
        case (idx)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            3:       return 6;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/vclk_main_div.sv
module vclk_main_div
    import vclk_pkg::*;
#(
    parameter int SRC_W = 3,
    parameter int DIV_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [(1<<SRC_W)-1:0] src_tick_i,
    input  logic [SRC_W-1:0]      src_sel_i,
    input  logic                  glb_en_i,
    input  logic                  soft_rst_i,
    input  logic                  div_en_i,
    input  logic                  div_rst_i,
    input  logic [DIV_W-1:0]      ratio_m1_i,
    output logic                  div_tick_o,
    output logic                  run_o
);

    logic             in_tick;
    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    assign run_o   = glb_en_i && !soft_rst_i && div_en_i && !div_rst_i;
    assign in_tick = src_tick_i[src_sel_i];
    assign at_end  = (cnt_q >= ratio_m1_i);
    assign div_tick_o = run_o && in_tick && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run_o) begin
            cnt_q <= '0;
        end else if (in_tick) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

    // R2: a stopped divider sits at zero on the next cycle
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !run_o |=> (cnt_q == '0));

    // R1: every divided pulse restarts the count
    a_r1_wrap_after_tick: assert property (@(posedge clk) disable iff (rst)
        div_tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/vclk_tap_gen.sv
module vclk_tap_gen
    import vclk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic                div_tick_i,
    input  logic [NUM_TAPS-1:0] gate_i,
    output logic [NUM_TAPS-1:0] tap_o
);

    logic [NUM_TAPS-1:0] raw;

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        localparam int R = tap_ratio(k);
        if (R == 1) begin : g_pass
            assign raw[k] = div_tick_i;
        end else begin : g_mod
            localparam int W = $clog2(R);
            logic [W-1:0] c_q;
            always_ff @(posedge clk) begin
                if (rst || clr_i) begin
                    c_q <= '0;
                end else if (div_tick_i) begin
                    c_q <= (c_q == W'(R - 1)) ? '0 : c_q + 1'b1;
                end
            end
            assign raw[k] = div_tick_i && (c_q == '0);
        end
        assign tap_o[k] = raw[k] && gate_i[k];
    end

    // R3, R8: the slowest tap only fires where every faster tap fires as well
    a_r3_tap_nesting: assert property (@(posedge clk) disable iff (rst)
        raw[4] |-> (raw[3] && raw[2] && raw[1] && raw[0]));

    // R3: the /6 tap coincides with the /2 tap
    a_r3_six_on_two: assert property (@(posedge clk) disable iff (rst)
        raw[3] |-> raw[1]);

endmodule

// File: rtl/vclk_cons_gate.sv
module vclk_cons_gate
    import vclk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TAPS-1:0] taps_i,
    input  cons_cfg_t           cfg_i,
    output logic                out_o
);

    logic pick;

    always_comb begin
        pick = 1'b0;
        for (int k = 0; k < NUM_TAPS; k++) begin
            if (cfg_i.sel == SEL_W'(k)) pick = taps_i[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_o <= 1'b0;
        else     out_o <= pick && cfg_i.en;
    end

    // R5: codes beyond the last tap give no pulse
    a_r5_bad_code_low: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.sel >= SEL_W'(NUM_TAPS)) |=> !out_o);

    // R6: a closed consumer gate gives no pulse
    a_r6_gate_low: assert property (@(posedge clk) disable iff (rst)
        !cfg_i.en |=> !out_o);

endmodule

// File: rtl/vclk_tap_tree.sv
module vclk_tap_tree
    import vclk_pkg::*;
#(
    parameter int SRC_W = 3,
    parameter int DIV_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [(1<<SRC_W)-1:0] src_tick_i,
    input  logic [SRC_W-1:0]      src_sel_i,
    input  logic                  glb_en_i,
    input  logic                  soft_rst_i,
    input  logic [DIV_W-1:0]      div_ratio_m1_i,
    input  logic                  div_en_i,
    input  logic                  div_rst_i,
    input  logic [NUM_TAPS-1:0]   tap_gate_i,
    input  logic [SEL_W-1:0]      hdmi_sel_i,
    input  logic                  hdmi_en_i,
    input  logic [SEL_W-1:0]      encp_sel_i,
    input  logic                  encp_en_i,
    input  logic [SEL_W-1:0]      enci_sel_i,
    input  logic                  enci_en_i,
    output logic                  hdmi_pix_o,
    output logic                  encp_clk_o,
    output logic                  enci_clk_o
);

    logic                div_tick;
    logic                run;
    logic [NUM_TAPS-1:0] taps;
    cons_cfg_t           cfg  [NUM_CONS];
    logic [NUM_CONS-1:0] outs;

    vclk_main_div #(.SRC_W(SRC_W), .DIV_W(DIV_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .src_tick_i (src_tick_i),
        .src_sel_i  (src_sel_i),
        .glb_en_i   (glb_en_i),
        .soft_rst_i (soft_rst_i),
        .div_en_i   (div_en_i),
        .div_rst_i  (div_rst_i),
        .ratio_m1_i (div_ratio_m1_i),
        .div_tick_o (div_tick),
        .run_o      (run)
    );

    vclk_tap_gen u_taps (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (!run),
        .div_tick_i (div_tick),
        .gate_i     (tap_gate_i),
        .tap_o      (taps)
    );

    assign cfg[0] = '{sel: hdmi_sel_i, en: hdmi_en_i};
    assign cfg[1] = '{sel: encp_sel_i, en: encp_en_i};
    assign cfg[2] = '{sel: enci_sel_i, en: enci_en_i};

    for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
        vclk_cons_gate u_gate (
            .clk    (clk),
            .rst    (rst),
            .taps_i (taps),
            .cfg_i  (cfg[c]),
            .out_o  (outs[c])
        );
    end

    assign hdmi_pix_o = outs[0];
    assign encp_clk_o = outs[1];
    assign enci_clk_o = outs[2];

    // R7: global enable off silences every consumer
    a_r7_global_off: assert property (@(posedge clk) disable iff (rst)
        !glb_en_i |=> (outs == '0));

    // R2: a disabled or reset divider silences every consumer
    a_r2_div_stopped: assert property (@(posedge clk) disable iff (rst)
        (!div_en_i || div_rst_i) |=> (outs == '0));

    // R8: soft reset silences every consumer
    a_r8_soft_hold: assert property (@(posedge clk) disable iff (rst)
        soft_rst_i |=> (outs == '0));

endmodule

// File: tb/vclk_tap_tree_test.sv
module vclk_tap_tree_test;

    localparam int WIN    = 1440;
    localparam int SETTLE = 200;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] src_tick;
    logic [2:0] src_sel;
    logic       glb_en, soft_rst, div_en, div_rst;
    logic [7:0] ratio_m1;
    logic [4:0] gates;
    logic [3:0] hs, ps, is;
    logic       he, pe, ie;
    logic       hdmi_pix, encp_clk, enci_clk;

    int checks = 0;
    int fails  = 0;
    int ph3    = 0;

    always #10 clk = ~clk;

    vclk_tap_tree uut (
        .clk            (clk),
        .rst            (rst),
        .src_tick_i     (src_tick),
        .src_sel_i      (src_sel),
        .glb_en_i       (glb_en),
        .soft_rst_i     (soft_rst),
        .div_ratio_m1_i (ratio_m1),
        .div_en_i       (div_en),
        .div_rst_i      (div_rst),
        .tap_gate_i     (gates),
        .hdmi_sel_i     (hs),
        .hdmi_en_i      (he),
        .encp_sel_i     (ps),
        .encp_en_i      (pe),
        .enci_sel_i     (is),
        .enci_en_i      (ie),
        .hdmi_pix_o     (hdmi_pix),
        .encp_clk_o     (encp_clk),
        .enci_clk_o     (enci_clk)
    );

    // Source 0 ticks every cycle, source 1 every third cycle, the rest never (R9).
    always @(negedge clk) begin
        ph3 <= (ph3 == 2) ? 0 : ph3 + 1;
        src_tick <= {6'b0, (ph3 == 2), 1'b1};
    end

    typedef struct packed {
        logic [2:0] src;
        logic [7:0] m1;
        logic [4:0] gt;
        logic [3:0] h, p, i;
        logic [2:0] en;      // {hdmi, encp, enci}
        logic [7:0] per_h, per_p, per_i;  // expected period, 0 = silent
    } vec_t;

    localparam vec_t VECS [9] = '{
        // R1 R3 R5: ratio 1, taps /1 /2 /4
        '{3'd0, 8'd0,  5'b11111, 4'd0, 4'd1, 4'd2, 3'b111, 8'd1,   8'd2,  8'd4},
        // R1 R3 R5: ratio 3, taps /6 /12 /1
        '{3'd0, 8'd2,  5'b11111, 4'd3, 4'd4, 4'd0, 3'b111, 8'd18,  8'd36, 8'd3},
        // R1 R3: ratio 5, taps /2 /4 /6
        '{3'd0, 8'd4,  5'b11111, 4'd1, 4'd2, 4'd3, 3'b111, 8'd10,  8'd20, 8'd30},
        // R9: source 1 (every 3rd cycle), ratio 2, taps /1 /2 /12
        '{3'd1, 8'd1,  5'b11111, 4'd0, 4'd1, 4'd4, 3'b111, 8'd6,   8'd12, 8'd72},
        // R4: /2 tap gated off
        '{3'd0, 8'd0,  5'b11101, 4'd1, 4'd0, 4'd2, 3'b111, 8'd0,   8'd1,  8'd4},
        // R5: illegal codes 5 and 15
        '{3'd0, 8'd0,  5'b11111, 4'd5, 4'd15, 4'd0, 3'b111, 8'd0,  8'd0,  8'd1},
        // R6: only the progressive encoder gate open
        '{3'd0, 8'd0,  5'b11111, 4'd0, 4'd1, 4'd0, 3'b010, 8'd0,   8'd2,  8'd0},
        // R9: idle source 2
        '{3'd2, 8'd0,  5'b11111, 4'd0, 4'd1, 4'd2, 3'b111, 8'd0,   8'd0,  8'd0},
        // R1 R3: ratio 12, taps /12 /1 /6
        '{3'd0, 8'd11, 5'b11111, 4'd4, 4'd0, 4'd3, 3'b111, 8'd144, 8'd12, 8'd72}
    };

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        src_sel = v.src; ratio_m1 = v.m1; gates = v.gt;
        hs = v.h; ps = v.p; is = v.i;
        he = v.en[2]; pe = v.en[1]; ie = v.en[0];
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic count_win(output int nh, output int np, output int ni);
        nh = 0; np = 0; ni = 0;
        repeat (WIN) begin
            @(negedge clk);
            nh += int'(hdmi_pix);
            np += int'(encp_clk);
            ni += int'(enci_clk);
        end
    endtask

    function automatic int exp_cnt(input logic [7:0] per);
        return (per == 0) ? 0 : WIN / int'(per);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int nh, np, ni;
        int fh, fp, fi;
        rst = 1'b1; src_tick = 8'h01; src_sel = 3'd0;
        glb_en = 1'b1; soft_rst = 1'b0; div_en = 1'b1; div_rst = 1'b0;
        ratio_m1 = 8'd0; gates = 5'b11111;
        hs = 4'd0; ps = 4'd0; is = 4'd0; he = 1'b1; pe = 1'b1; ie = 1'b1;

        // R10: outputs low while reset is held with everything enabled
        repeat (4) @(negedge clk);
        check_eq("R10 reset hdmi", int'(hdmi_pix), 0);
        check_eq("R10 reset encp", int'(encp_clk), 0);
        check_eq("R10 reset enci", int'(enci_clk), 0);
        @(negedge clk);
        rst = 1'b0;

        foreach (VECS[n]) begin
            apply(VECS[n]);
            count_win(nh, np, ni);
            check_eq($sformatf("R1/R3/R4/R5/R6/R9 vec%0d hdmi", n), nh, exp_cnt(VECS[n].per_h));
            check_eq($sformatf("R1/R3/R4/R5/R6/R9 vec%0d encp", n), np, exp_cnt(VECS[n].per_p));
            check_eq($sformatf("R1/R3/R4/R5/R6/R9 vec%0d enci", n), ni, exp_cnt(VECS[n].per_i));
        end

        // R2: divider enable off
        apply(VECS[0]);
        div_en = 1'b0;
        count_win(nh, np, ni);
        check_eq("R2 div_en off", nh + np + ni, 0);
        div_en = 1'b1;

        // R2: divider reset held
        div_rst = 1'b1;
        count_win(nh, np, ni);
        check_eq("R2 div_rst on", nh + np + ni, 0);
        div_rst = 1'b0;

        // R7: global enable off
        glb_en = 1'b0;
        count_win(nh, np, ni);
        check_eq("R7 global off", nh + np + ni, 0);
        glb_en = 1'b1;

        // R8 R11: taps /2 /4 /12 all fire on the first cycle after soft reset release
        @(negedge clk);
        src_sel = 3'd0; ratio_m1 = 8'd0; gates = 5'b11111;
        hs = 4'd1; ps = 4'd2; is = 4'd4; he = 1'b1; pe = 1'b1; ie = 1'b1;
        soft_rst = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R8 silent during soft reset", int'(hdmi_pix) + int'(encp_clk) + int'(enci_clk), 0);
        soft_rst = 1'b0;
        fh = -1; fp = -1; fi = -1;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (hdmi_pix && fh < 0) fh = t;
            if (encp_clk && fp < 0) fp = t;
            if (enci_clk && fi < 0) fi = t;
        end
        check_eq("R11 first hdmi pulse cycle", fh, 0);
        check_eq("R8 encp aligned with hdmi", fp, fh);
        check_eq("R8 enci aligned with hdmi", fi, fh);

        finish_run();
    end

endmodule